// File: doc/BRIEF.md
# Integrate-and-Dump Accumulator Bank

This block sums correlator products for one receiver channel on four arms: in-phase and quadrature on the prompt arm, and in-phase and quadrature on the dithering arm. Each arm has its own saturating 14-bit accumulator. A product is added on every cycle that the sample-valid strobe is high. On a dump strobe the four running sums are copied into read registers, and the accumulators start again from the sample presented in that same cycle.

Software reads a 16-bit word per arm through a select and strobe interface. The word holds the dumped sum, a constant-low bit and the live saturation flag of that arm. Once a dump has loaded the read registers they are protected. Later dumps still restart the accumulators but leave the registers alone and raise a missed-dump flag. The protection is lifted by a strobed read of the last arm, the prompt quadrature word.

Top module: `corr_dump_bank`

## Requirements
- R1: After reset every read word is zero, every saturation flag is low, and both `prot_o` and `missed_o` are low.
- R2: A lane's product is added to its accumulator only in cycles where `smp_vld_i` is high. Products presented while it is low have no effect.
- R3: An accepted dump loads bits 15:2 of each read word with that arm's two's complement sum as it stood before the dump cycle, and bit 1 of every read word is always 0.
- R4: In a dump cycle each accumulator restarts at the current product if `smp_vld_i` is high, or at zero otherwise, so no sample is lost across the dump.
- R5: When adding a product would bring the sum to +8191 or above, or to -8192 or below, the arm's flag is set and its sum freezes at the last value below the limit. Further products are ignored until the next dump.
- R6: Bit 0 of a read word shows the live flag of that arm. The flag is cleared by the restart at a dump.
- R7: A sum dumped after saturation has bit 15 low if the limit was positive and high if it was negative.
- R8: An accepted dump sets `prot_o`. While `prot_o` is high a dump leaves every read word unchanged, still restarts the accumulators, and sets `missed_o`.
- R9: A cycle with `rd_stb_i` high and `rd_sel_i` = 3 clears `prot_o` and `missed_o`. Strobed reads of indices 0 to 2 change neither.
- R10: A dump in the same cycle as the releasing read of index 3 is accepted: the words load, `prot_o` stays high and `missed_o` is low.
- R11: Arm index k, which is both the `rd_sel_i` value and product lane `prod_i[k*8 +: 8]`, maps as follows: 0 dithering I, 1 dithering Q, 2 prompt I, 3 prompt Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Product lanes carry a sample this cycle |
| prod_i | input | 32 | Four signed 8-bit products, lane k at bits k*8+7:k*8 |
| dump_i | input | 1 | Dump strobe |
| rd_sel_i | input | 2 | Arm index of the word to read |
| rd_stb_i | input | 1 | Read strobe; on index 3 it releases protection |
| rd_data_o | output | 16 | {sum[13:0], 1'b0, live flag} of the selected arm |
| prot_o | output | 1 | Read words are protected |
| missed_o | output | 1 | A dump was dropped while protected |

## Verification
The bench drives products biased in one direction until arms saturate. It checks that the frozen value is the last sum before the limit. A design that stored the clamped limit would dump +8191, and a design that kept accumulating after saturation would wrap the sign bit. It also places dumps and sample-valid pulses in the same cycle, where a design that dropped the restart sample would show a hold value off by one product. Dumps are issued under protection and on the exact cycle of the releasing read. A wrong ordering of these two events either loses the dump or leaves `missed_o` set.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int unsigned CDB_SUM_W = 14;
  localparam int unsigned CDB_NARM  = 4;

  // Arm order on the product lanes and the read select; the release arm is last.
  typedef enum logic [1:0] {
    ARM_DITH_I = 2'd0,
    ARM_DITH_Q = 2'd1,
    ARM_PRM_I  = 2'd2,
    ARM_PRM_Q  = 2'd3
  } arm_e;
endpackage

// File: rtl/cdb_accum.sv
module cdb_accum #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned SUM_W = cdb_pkg::CDB_SUM_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    dump_i,
  input  logic signed [IN_W-1:0]  prod_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic                    ovf_o
);
  localparam int unsigned EXT_W = SUM_W + 1;
  localparam logic signed [EXT_W-1:0] LIM_HI = $signed({2'b00, {(SUM_W-1){1'b1}}});
  localparam logic signed [EXT_W-1:0] LIM_LO = $signed({2'b11, {(SUM_W-1){1'b0}}});

  if (IN_W >= SUM_W) begin : g_bad_width
    $error("cdb_accum: IN_W must be below SUM_W");
  end

  logic signed [SUM_W-1:0] sum_q, sum_d;
  logic                    ovf_q, ovf_d;
  logic signed [EXT_W-1:0] prod_x, cand;
  logic                    hit_lim;
  logic                    en;

  always_comb begin
    prod_x  = $signed({{(EXT_W-IN_W){prod_i[IN_W-1]}}, prod_i});
    cand    = $signed({sum_q[SUM_W-1], sum_q}) + prod_x;
    hit_lim = (cand >= LIM_HI) || (cand <= LIM_LO);
    en      = vld_i | dump_i;
    sum_d   = sum_q;
    ovf_d   = ovf_q;
    if (dump_i) begin
      sum_d = vld_i ? prod_x[SUM_W-1:0] : '0;
      ovf_d = 1'b0;
    end else if (vld_i && !ovf_q) begin
      if (hit_lim) ovf_d = 1'b1;
      else         sum_d = cand[SUM_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      sum_q <= sum_d;
      ovf_q <= ovf_d;
    end
  end

  assign sum_o = sum_q;
  assign ovf_o = ovf_q;

  p_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !dump_i) |=> ($stable(sum_q) && ovf_q));
  p_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed({sum_q[SUM_W-1], sum_q}) < LIM_HI) && ($signed({sum_q[SUM_W-1], sum_q}) > LIM_LO));
  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_i && vld_i) |=> (sum_q == SUM_W'($past(prod_i))));
  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_i |=> !ovf_q);
endmodule

// File: rtl/cdb_guard.sv
module cdb_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dump_i,
  input  logic rel_i,
  output logic load_o,
  output logic prot_o,
  output logic missed_o
);
  logic prot_q, prot_d;
  logic miss_q, miss_d;
  logic accept;

  always_comb begin
    accept = dump_i && (!prot_q || rel_i);
    prot_d = prot_q;
    miss_d = miss_q;
    if (accept)     prot_d = 1'b1;
    else if (rel_i) prot_d = 1'b0;
    if (rel_i)       miss_d = 1'b0;
    else if (dump_i && prot_q) miss_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      prot_q <= prot_d;
      miss_q <= miss_d;
    end
  end

  assign load_o   = accept;
  assign prot_o   = prot_q;
  assign missed_o = miss_q;

  p_missed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_i && prot_q && !rel_i) |=> (miss_q && prot_q));
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !dump_i) |=> (!prot_q && !miss_q));
  p_same_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && dump_i) |=> (prot_q && !miss_q));
endmodule

// File: rtl/corr_dump_bank.sv
module corr_dump_bank #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned SUM_W = cdb_pkg::CDB_SUM_W,
  parameter int unsigned NARM  = cdb_pkg::CDB_NARM
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_vld_i,
  input  logic [NARM*IN_W-1:0]     prod_i,
  input  logic                     dump_i,
  input  logic [$clog2(NARM)-1:0]  rd_sel_i,
  input  logic                     rd_stb_i,
  output logic [SUM_W+1:0]         rd_data_o,
  output logic                     prot_o,
  output logic                     missed_o
);
  localparam int unsigned SEL_W = $clog2(NARM);
  localparam logic [SEL_W-1:0] REL_IDX = SEL_W'(NARM-1);

  logic [NARM-1:0][SUM_W-1:0] sum_w;
  logic [NARM-1:0][SUM_W-1:0] hold_q;
  logic [NARM-1:0]            ovf_w;
  logic                       load;
  logic                       rel;

  assign rel = rd_stb_i && (rd_sel_i == REL_IDX);

  cdb_guard u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dump_i  (dump_i),
    .rel_i   (rel),
    .load_o  (load),
    .prot_o  (prot_o),
    .missed_o(missed_o)
  );

  for (genvar a = 0; a < NARM; a++) begin : g_arm
    logic signed [SUM_W-1:0] arm_sum;

    cdb_accum #(.IN_W(IN_W), .SUM_W(SUM_W)) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (smp_vld_i),
      .dump_i(dump_i),
      .prod_i($signed(prod_i[a*IN_W +: IN_W])),
      .sum_o (arm_sum),
      .ovf_o (ovf_w[a])
    );
    assign sum_w[a] = arm_sum;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   hold_q[a] <= '0;
      else if (load) hold_q[a] <= sum_w[a];
    end
  end

  assign rd_data_o = {hold_q[rd_sel_i], 1'b0, ovf_w[rd_sel_i]};

  p_hold_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_i && prot_o && !rel) |=> $stable(hold_q));
  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dump_i |=> $stable(hold_q));
endmodule

// File: tb/corr_dump_bank_tb_top.sv
`timescale 1ns/1ps
module corr_dump_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_vld;
  logic [31:0] prod;
  logic        dump;
  logic [1:0]  rd_sel;
  logic        rd_stb;
  logic [15:0] rd_data;
  logic        prot, missed;

  logic signed [7:0] lane [4];
  int  m_sum [4];
  int  m_hold [4];
  bit  m_ovf [4];
  bit  m_prot, m_missed;
  int  n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  corr_dump_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(smp_vld), .prod_i(prod),
    .dump_i(dump), .rd_sel_i(rd_sel), .rd_stb_i(rd_stb),
    .rd_data_o(rd_data), .prot_o(prot), .missed_o(missed)
  );

  function automatic logic [15:0] exp_word(int k);
    logic [13:0] h;
    h = 14'(m_hold[k]);
    return {h, 1'b0, m_ovf[k]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_update(bit vld, bit dmp, int sel, bit stb);
    bit rel, accept;
    rel = stb && (sel == 3);
    accept = dmp && (!m_prot || rel);
    for (int a = 0; a < 4; a++) if (accept) m_hold[a] = m_sum[a];
    if (rel) m_missed = 0;
    else if (dmp && m_prot) m_missed = 1;
    if (accept) m_prot = 1;
    else if (rel) m_prot = 0;
    for (int a = 0; a < 4; a++) begin
      int p, c;
      p = int'(lane[a]);
      if (dmp) begin
        m_sum[a] = vld ? p : 0;
        m_ovf[a] = 0;
      end else if (vld && !m_ovf[a]) begin
        c = m_sum[a] + p;
        if (c >= 8191 || c <= -8192) m_ovf[a] = 1;
        else m_sum[a] = c;
      end
    end
  endtask

  task automatic step(string req, bit vld, bit dmp, int sel, bit stb);
    smp_vld = vld; dump = dmp; rd_sel = 2'(sel); rd_stb = stb;
    prod = {lane[3], lane[2], lane[1], lane[0]};
    @(posedge clk);
    model_update(vld, dmp, sel, stb);
    @(negedge clk);
    chk(req, rd_data, exp_word(sel));
    chk("R8 prot", {15'd0, prot}, {15'd0, m_prot});
    chk("R8 missed", {15'd0, missed}, {15'd0, m_missed});
  endtask

  task automatic check_all(string req);
    smp_vld = 0; dump = 0; rd_stb = 0;
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k);
      #0.5;
      chk(req, rd_data, exp_word(k));
    end
  endtask

  task automatic set_lanes(int l0, int l1, int l2, int l3);
    lane[0] = 8'(l0); lane[1] = 8'(l1); lane[2] = 8'(l2); lane[3] = 8'(l3);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; smp_vld = 0; dump = 0; rd_sel = 0; rd_stb = 0;
    set_lanes(0, 0, 0, 0);
    prod = '0;
    for (int a = 0; a < 4; a++) begin m_sum[a] = 0; m_hold[a] = 0; m_ovf[a] = 0; end
    m_prot = 0; m_missed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    chk("R1 prot", {15'd0, prot}, 16'd0);
    chk("R1 missed", {15'd0, missed}, 16'd0);

    // R11 / R2: distinct lanes, invalid samples carry a large value
    set_lanes(1, 2, 3, 4);
    for (int i = 0; i < 5; i++) begin
      set_lanes(1, 2, 3, 4);
      step("R2", 1, 0, 0, 0);
      set_lanes(50, 50, 50, 50);
      step("R2", 0, 0, 0, 0);
    end
    set_lanes(7, -7, 9, -9);
    step("R4", 1, 1, 0, 0);
    check_all("R11");
    chk("R11 prompt Q", rd_data, {14'd20, 2'b00});
    // R4: restart sample counted in next dump
    set_lanes(1, 1, 1, 1);
    step("R9", 0, 0, 3, 1);
    step("R4", 1, 0, 0, 0);
    step("R4", 0, 1, 0, 0);
    check_all("R4");
    step("R9", 0, 0, 3, 1);

    // R5 / R6 / R7: saturate arm 0 upward and arm 1 downward
    set_lanes(100, -100, 1, 0);
    for (int i = 0; i < 100; i++) step("R5", 1, 0, i % 4, 0);
    check_all("R5");
    chk("R6 flag live", {15'd0, m_ovf[0]}, 16'd1);
    step("R7", 0, 1, 0, 0);
    check_all("R6");
    rd_sel = 0; #0.5; chk("R7 up sign", {15'd0, rd_data[15]}, 16'd0);
    rd_sel = 1; #0.5; chk("R7 down sign", {15'd0, rd_data[15]}, 16'd1);
    chk("R5 frozen value", rd_data, exp_word(1));

    // R8: dump under protection is dropped
    set_lanes(3, 3, 3, 3);
    for (int i = 0; i < 4; i++) step("R8", 1, 0, 0, 0);
    step("R8", 1, 1, 0, 0);
    check_all("R8");
    // R9: strobed reads of other indices do not release
    step("R9", 0, 0, 1, 1);
    step("R9", 0, 0, 2, 1);
    chk("R9 still prot", {15'd0, prot}, 16'd1);
    // R10: dump on the releasing read is accepted
    step("R10", 1, 0, 0, 0);
    step("R10", 1, 1, 3, 1);
    chk("R10 prot", {15'd0, prot}, 16'd1);
    chk("R10 missed", {15'd0, missed}, 16'd0);
    check_all("R10");

    // Random phase with biased segments to reach both limits
    void'($urandom(32'h5EED_1234));
    for (int seg = 0; seg < 8; seg++) begin
      bit biased;
      biased = seg[0];
      for (int i = 0; i < 400; i++) begin
        bit v, d, s;
        int sel;
        for (int a = 0; a < 4; a++) begin
          if (biased) begin
            int mag;
            mag = 90 + int'($urandom_range(0, 37));
            lane[a] = 8'(((a + seg) % 2 == 0) ? mag : -mag);
          end else begin
            lane[a] = 8'(int'($urandom_range(0, 255)) - 128);
          end
        end
        v   = ($urandom_range(0, 9) < 8);
        d   = ($urandom_range(0, 119) == 0);
        s   = ($urandom_range(0, 19) == 0);
        sel = int'($urandom_range(0, 3));
        step("R3", v, d, sel, s);
      end
      check_all("R3");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule